// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 memory from power-up to a usable state. After reset it keeps the clock-enable pin low while it sends idle commands for the required settling time. It then raises clock-enable and issues the fixed series of precharge, mode-register and refresh commands that the memory needs before normal operation. Each wait is computed from the clock period and a time in nanoseconds, or given directly as a cycle count.

The mode-register words are built from parameters for burst length, CAS latency and write recovery. The extended-register words set DLL enable and the two off-chip-driver calibration steps (default, then exit). After the last command the block raises `init_done`, and a command scheduler can take over the pins.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `mem_cke` is 0, `mem_cmd` is NOP (`3'b111`), `mem_ba` and `mem_addr` are 0, and `init_done` is 0.
- R2: After reset is released, `mem_cke` stays 0 for exactly ceil(PWRUP_NS*1000/CLK_PERIOD_PS) cycles. It then goes to 1 and stays at 1 until the next reset. While `mem_cke` is 0, the command is NOP.
- R3: The first command is a precharge of all banks (`mem_cmd`=`3'b010` with `mem_addr`[10]=1, all other address bits 0). It appears ceil(CKE_NS*1000/CLK_PERIOD_PS) cycles after the cycle in which `mem_cke` rose.
- R4: Three extended-register writes follow, each a load-mode command (`mem_cmd`=`3'b000`). The first uses bank code 2 with address 0, the second uses bank code 3 with address 0, and the third uses bank code 1 with address 0 (A0=0, DLL enabled).
- R5: Next comes a main mode-register write (bank code 0) with A8=1, which resets the DLL. The following command comes max(DLL_LOCK_CYC, TMRD_CYC) cycles later.
- R6: After the DLL wait, the block issues a precharge of all banks and then two auto refreshes (`mem_cmd`=`3'b001`, address 0). It then issues a main mode-register write with A8=0. The gap after a precharge is ceil(TRP_NS/period). The gap after each refresh is ceil(TRFC_NS/period), and never less than 2.
- R7: The last two commands are extended-register writes with bank code 1. The first has A9:A7=111 (driver calibration default). The second has A9:A7=000 (calibration exit).
- R8: In the main mode-register word, A2:A0 is 010 for burst length 4 and 011 for burst length 8. A6:A4 holds the CAS latency in binary (2 to 5). A11:A9 holds write recovery minus one (001 to 101 for 2 to 6). A3, A7 and A12 are 0.
- R9: Every command lasts one cycle, with NOP (address and bank 0) between commands. After each mode-register write, the next command comes max(TMRD_CYC, 2) cycles later.
- R10: `init_done` goes to 1 one cycle after the final command. It stays at 1, with NOP and `mem_cke`=1, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-side clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_cke | output | 1 | Clock enable to the memory |
| mem_cmd | output | 3 | Command as {RAS#, CAS#, WE#}: 111 NOP, 010 precharge, 001 refresh, 000 load mode |
| mem_ba | output | BA_W | Bank address; selects which mode register is written |
| mem_addr | output | ADDR_W | Address bus carrying A10 or the register word |
| init_done | output | 1 | High once the sequence is complete |

## Verification
The bench builds the block with a 4 ns period and a power-up wait of 2000 ns instead of 200 µs. This shortens the full sequence to under a thousand cycles, so every cycle of it can be compared against a hand-computed schedule. It uses burst length 8, CAS latency 5 and write recovery 6. These values differ from the defaults, so the upper burst code and the top of the CAS and recovery ranges appear in the register words. The 15 ns precharge time does not divide the period, so the round-up is exercised. A second run is cut off by a reset partway through the sequence.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    // Command as {RAS#, CAS#, WE#}
    typedef enum logic [2:0] {
        CMD_LMR = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_NOP = 3'b111
    } cmd_e;

    // Which address word goes with a step
    typedef enum logic [2:0] {
        ADR_ZERO,
        ADR_ALLBANK,
        ADR_MR_DLLRST,
        ADR_MR_RUN,
        ADR_OCD_DEFAULT
    } adr_sel_e;

    // Which wait follows a step
    typedef enum logic [2:0] {
        GAP_MRD,
        GAP_RP,
        GAP_RFC,
        GAP_DLL,
        GAP_END
    } gap_e;

    typedef struct packed {
        cmd_e     cmd;
        logic [1:0] ba;
        adr_sel_e sel;
        gap_e     gap;
    } step_t;

    localparam int unsigned N_STEPS = 11;

    typedef enum logic [1:0] {
        PH_PWRUP,
        PH_CKEWAIT,
        PH_GAP,
        PH_DONE
    } phase_e;

    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period_ps);
        int unsigned c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [2:0] bl_code(int unsigned bl);
        return (bl == 8) ? 3'b011 : 3'b010;
    endfunction

    function automatic logic [2:0] cl_code(int unsigned cl);
        return 3'(cl);
    endfunction

    function automatic logic [2:0] wr_code(int unsigned wr);
        return 3'(wr - 1);
    endfunction

    // Fixed command order after CKE rises
    function automatic step_t step_of(logic [3:0] idx);
        step_t s;
        case (idx)
            4'd0:    s = '{CMD_PRE, 2'd0, ADR_ALLBANK,     GAP_RP};
            4'd1:    s = '{CMD_LMR, 2'd2, ADR_ZERO,        GAP_MRD};
            4'd2:    s = '{CMD_LMR, 2'd3, ADR_ZERO,        GAP_MRD};
            4'd3:    s = '{CMD_LMR, 2'd1, ADR_ZERO,        GAP_MRD};
            4'd4:    s = '{CMD_LMR, 2'd0, ADR_MR_DLLRST,   GAP_DLL};
            4'd5:    s = '{CMD_PRE, 2'd0, ADR_ALLBANK,     GAP_RP};
            4'd6:    s = '{CMD_REF, 2'd0, ADR_ZERO,        GAP_RFC};
            4'd7:    s = '{CMD_REF, 2'd0, ADR_ZERO,        GAP_RFC};
            4'd8:    s = '{CMD_LMR, 2'd0, ADR_MR_RUN,      GAP_MRD};
            4'd9:    s = '{CMD_LMR, 2'd1, ADR_OCD_DEFAULT, GAP_MRD};
            4'd10:   s = '{CMD_LMR, 2'd1, ADR_ZERO,        GAP_END};
            default: s = '{CMD_NOP, 2'd0, ADR_ZERO,        GAP_END};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
    parameter int unsigned W       = 16,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/ddr2_init_modereg.sv
module ddr2_init_modereg
    import ddr2_init_pkg::*;
#(
    parameter int unsigned ADDR_W    = 14,
    parameter int unsigned BURST_LEN = 4,
    parameter int unsigned CAS_LAT   = 3,
    parameter int unsigned WR_RECOV  = 3
) (
    input  adr_sel_e          sel,
    output logic [ADDR_W-1:0] word
);
    always_comb begin
        word = '0;
        case (sel)
            ADR_ALLBANK: word[10] = 1'b1;
            ADR_MR_DLLRST, ADR_MR_RUN: begin
                word[2:0]  = bl_code(BURST_LEN);
                word[6:4]  = cl_code(CAS_LAT);
                word[11:9] = wr_code(WR_RECOV);
                word[8]    = (sel == ADR_MR_DLLRST);
            end
            ADR_OCD_DEFAULT: word[9:7] = 3'b111;
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 4000,
    parameter int unsigned PWRUP_NS      = 200000,
    parameter int unsigned CKE_NS        = 400,
    parameter int unsigned TRP_NS        = 15,
    parameter int unsigned TRFC_NS       = 128,
    parameter int unsigned TMRD_CYC      = 2,
    parameter int unsigned DLL_LOCK_CYC  = 200,
    parameter int unsigned BURST_LEN     = 4,
    parameter int unsigned CAS_LAT       = 3,
    parameter int unsigned WR_RECOV      = 3,
    parameter int unsigned ADDR_W        = 14,
    parameter int unsigned BA_W          = 2
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_cke,
    output logic [2:0]        mem_cmd,
    output logic [BA_W-1:0]   mem_ba,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              init_done
);
    localparam int unsigned PWRUP_CYC = ns_to_cyc(PWRUP_NS, CLK_PERIOD_PS);
    localparam int unsigned CKE_CYC   = ns_to_cyc(CKE_NS, CLK_PERIOD_PS);
    // Every gap is at least two cycles so commands never touch
    localparam int unsigned MRD_GAP   = umax(TMRD_CYC, 2);
    localparam int unsigned RP_GAP    = umax(ns_to_cyc(TRP_NS, CLK_PERIOD_PS), 2);
    localparam int unsigned RFC_GAP   = umax(ns_to_cyc(TRFC_NS, CLK_PERIOD_PS), 2);
    localparam int unsigned DLL_GAP   = umax(DLL_LOCK_CYC, MRD_GAP);
    localparam int unsigned MAX_WAIT  = umax(umax(PWRUP_CYC, CKE_CYC),
                                        umax(DLL_GAP, umax(RP_GAP, RFC_GAP)));
    localparam int unsigned CNT_W     = $clog2(MAX_WAIT + 1);
    localparam logic [3:0]  LAST_IDX  = 4'(N_STEPS - 1);

    phase_e            phase_q;
    logic [3:0]        idx_q;
    logic [3:0]        next_idx;
    step_t             next_step;
    logic              expired;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic [ADDR_W-1:0] next_word;
    logic              cke_q;
    logic              done_q;
    cmd_e              cmd_q;
    logic [BA_W-1:0]   ba_q;
    logic [ADDR_W-1:0] addr_q;

    function automatic int unsigned gap_cyc(gap_e g);
        case (g)
            GAP_MRD: return MRD_GAP;
            GAP_RP:  return RP_GAP;
            GAP_RFC: return RFC_GAP;
            GAP_DLL: return DLL_GAP;
            default: return 1;
        endcase
    endfunction

    assign next_idx  = (phase_q == PH_CKEWAIT) ? 4'd0 : idx_q + 4'd1;
    assign next_step = step_of(next_idx);
    assign tmr_load  = expired && (phase_q != PH_DONE);
    assign tmr_val   = (phase_q == PH_PWRUP) ? CNT_W'(CKE_CYC - 1)
                                             : CNT_W'(gap_cyc(next_step.gap) - 1);

    ddr2_init_timer #(
        .W      (CNT_W),
        .RST_VAL(PWRUP_CYC - 1)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (expired)
    );

    ddr2_init_modereg #(
        .ADDR_W   (ADDR_W),
        .BURST_LEN(BURST_LEN),
        .CAS_LAT  (CAS_LAT),
        .WR_RECOV (WR_RECOV)
    ) u_modereg (
        .sel (next_step.sel),
        .word(next_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_PWRUP;
            idx_q   <= '0;
            cke_q   <= 1'b0;
            done_q  <= 1'b0;
            cmd_q   <= CMD_NOP;
            ba_q    <= '0;
            addr_q  <= '0;
        end else begin
            cmd_q  <= CMD_NOP;
            ba_q   <= '0;
            addr_q <= '0;
            if (expired) begin
                case (phase_q)
                    PH_PWRUP: begin
                        cke_q   <= 1'b1;
                        phase_q <= PH_CKEWAIT;
                    end
                    PH_CKEWAIT, PH_GAP: begin
                        if (phase_q == PH_GAP && idx_q == LAST_IDX) begin
                            done_q  <= 1'b1;
                            phase_q <= PH_DONE;
                        end else begin
                            idx_q   <= next_idx;
                            cmd_q   <= next_step.cmd;
                            ba_q    <= BA_W'(next_step.ba);
                            addr_q  <= next_word;
                            phase_q <= PH_GAP;
                        end
                    end
                    default: phase_q <= PH_DONE;
                endcase
            end
        end
    end

    assign mem_cke   = cke_q;
    assign mem_cmd   = cmd_q;
    assign mem_ba    = ba_q;
    assign mem_addr  = addr_q;
    assign init_done = done_q;
endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk
    import ddr2_init_pkg::*;
#(
    parameter int unsigned BURST_LEN = 4,
    parameter int unsigned CAS_LAT   = 3,
    parameter int unsigned ADDR_W    = 14,
    parameter int unsigned BA_W      = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_cke,
    input logic [2:0]        mem_cmd,
    input logic [BA_W-1:0]   mem_ba,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              init_done
);
    AST_CKE_HOLD: assert property (@(posedge clk) disable iff (rst) mem_cke |=> mem_cke); // R2
    AST_QUIET_CKE_LOW: assert property (@(posedge clk) disable iff (rst) !mem_cke |-> mem_cmd == CMD_NOP); // R2
    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (rst) mem_cmd == CMD_PRE |-> mem_addr[10]); // R3
    AST_MR_FIELDS: assert property (@(posedge clk) disable iff (rst) (mem_cmd == CMD_LMR && mem_ba == '0) |-> (mem_addr[2:0] == bl_code(BURST_LEN) && mem_addr[6:4] == cl_code(CAS_LAT))); // R8
    AST_ONE_CYCLE_CMD: assert property (@(posedge clk) disable iff (rst) mem_cmd != CMD_NOP |=> mem_cmd == CMD_NOP); // R9
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst) init_done |=> init_done); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) init_done |-> (mem_cmd == CMD_NOP && mem_cke)); // R10
endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(
    .BURST_LEN(BURST_LEN),
    .CAS_LAT  (CAS_LAT),
    .ADDR_W   (ADDR_W),
    .BA_W     (BA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_cke  (mem_cke),
    .mem_cmd  (mem_cmd),
    .mem_ba   (mem_ba),
    .mem_addr (mem_addr),
    .init_done(init_done)
);

// File: tb/ddr2_init_seq_test.sv
`timescale 1ns/1ps
module ddr2_init_seq_test;
    localparam int ADDR_W = 14;
    localparam int BA_W   = 2;
    // Hand-computed schedule for 4 ns period, 2000 ns power-up, 400 ns CKE wait
    localparam int CKE_RISE_N = 500;
    localparam int FIRST_CMD_N = 600;
    localparam int DONE_N = 883;

    typedef struct packed {
        logic [2:0]  c;
        logic [1:0]  b;
        logic [13:0] a;
        logic [15:0] g;
    } exp_t;

    // BL8 -> 011, CL5 -> 101 at A6:A4, WR6 -> 101 at A11:A9
    localparam exp_t VEC [11] = '{
        '{3'b010, 2'd0, 14'h0400, 16'd4},    // R3 precharge all
        '{3'b000, 2'd2, 14'h0000, 16'd2},    // R4 ext reg 2
        '{3'b000, 2'd3, 14'h0000, 16'd2},    // R4 ext reg 3
        '{3'b000, 2'd1, 14'h0000, 16'd2},    // R4 ext reg, DLL on
        '{3'b000, 2'd0, 14'd2899, 16'd200},  // R5 mode reg, DLL reset
        '{3'b010, 2'd0, 14'h0400, 16'd4},    // R6 precharge all
        '{3'b001, 2'd0, 14'h0000, 16'd32},   // R6 refresh
        '{3'b001, 2'd0, 14'h0000, 16'd32},   // R6 refresh
        '{3'b000, 2'd0, 14'd2643, 16'd2},    // R6 mode reg run
        '{3'b000, 2'd1, 14'h0380, 16'd2},    // R7 OCD default
        '{3'b000, 2'd1, 14'h0000, 16'd1}     // R7 OCD exit
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mem_cke;
    logic [2:0]        mem_cmd;
    logic [BA_W-1:0]   mem_ba;
    logic [ADDR_W-1:0] mem_addr;
    logic              init_done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ddr2_init_seq #(
        .CLK_PERIOD_PS(4000),
        .PWRUP_NS     (2000),
        .CKE_NS       (400),
        .TRP_NS       (15),
        .TRFC_NS      (128),
        .TMRD_CYC     (2),
        .DLL_LOCK_CYC (200),
        .BURST_LEN    (8),
        .CAS_LAT      (5),
        .WR_RECOV     (6),
        .ADDR_W       (ADDR_W),
        .BA_W         (BA_W)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .mem_cke  (mem_cke),
        .mem_cmd  (mem_cmd),
        .mem_ba   (mem_ba),
        .mem_addr (mem_addr),
        .init_done(init_done)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    function automatic string tag_of(int i);
        if (i == 0) return "R3";
        if (i <= 3) return "R4";
        if (i == 4) return "R5";
        if (i <= 8) return "R6";
        return "R7";
    endfunction

    // R1: reset state seen during reset
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 cke", 32'(mem_cke), 32'd0);
        chk("R1 cmd", 32'(mem_cmd), 32'h7);
        chk("R1 ba", 32'(mem_ba), 32'd0);
        chk("R1 addr", 32'(mem_addr), 32'd0);
        chk("R1 done", 32'(init_done), 32'd0);
        rst = 1'b0;
    endtask

    // Walk the schedule table cycle by cycle up to cycle last_n
    task automatic run_to(int last_n);
        int i = 0;
        int t = FIRST_CMD_N;
        for (int n = 1; n <= last_n; n++) begin
            @(negedge clk);
            if (i < 11 && n == t) begin
                chk({tag_of(i), " cmd"}, 32'(mem_cmd), 32'(VEC[i].c));
                chk({tag_of(i), " ba"}, 32'(mem_ba), 32'(VEC[i].b));
                chk({tag_of(i), " addr R8"}, 32'(mem_addr), 32'(VEC[i].a));
                t = t + int'(VEC[i].g);
                i++;
            end else begin
                chk("R9 nop", 32'({mem_cmd, mem_ba, mem_addr}), 32'({3'b111, 2'b00, 14'h0}));
            end
            chk("R2 cke", 32'(mem_cke), 32'(n >= CKE_RISE_N));
            chk("R10 done", 32'(init_done), 32'(n >= DONE_N));
        end
    endtask

    initial begin
        int watch = 0;
        while (!finished && watch < 200000) begin
            @(posedge clk);
            watch++;
        end
        if (!finished) begin
            n_fail++;
            $display("FAIL R10 watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1, then the full sequence and 40 idle cycles after done (R10)
        do_reset();
        run_to(DONE_N + 40);
        // Second run, cut off mid-sequence by reset
        do_reset();
        run_to(700);
        do_reset();
        // First cycle after release still in reset state (R1)
        @(negedge clk);
        chk("R1 post-release cke", 32'(mem_cke), 32'd0);
        chk("R1 post-release done", 32'(init_done), 32'd0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule